// File: doc/BRIEF.md
# Serial Adapter Host Register Block

This block is the processor-facing half of an asynchronous serial adapter. A host reaches four byte-wide locations through a two-bit address with separate read and write strobes. Two of those locations hold configuration: a line-format register (rate selection, receive clock source, character length, stop bits) and a mode register (terminal ready, receive interrupt mask, transmit control, echo, parity). The block decodes both into plain configuration fields for the transmitter, receiver and rate generator. It also drives the active-low terminal-ready and request-to-send outputs.

The block assembles a status byte from the receiver and transmitter flags and from the two active-low modem status inputs. Those inputs are synchronized inside the block before their edges are detected. It holds a single pending-interrupt bit, which drives the interrupt request. The bit is set by a full receive register, an empty transmit register, or any change on the modem lines, each gated by the mode register. Reading the status byte clears it. A write to the dedicated reset location returns the block to its power-up configuration whatever data is written.

Top module: `uart_host_regs`

## Requirements
- R1: Address 0 read returns `rx_data` and pulses `rx_read`; address 0 write pulses `tx_load`; address 1 read returns status; address 2 reads and writes the mode register; address 3 reads and writes the line-format register.
- R2: A write to address 1 clears the mode register, the line-format register and the pending interrupt, regardless of `wdata`.
- R3: Line-format bits decode as: [3:0] to `baud_sel` (0 = external 16x clock), [4] to `rx_clk_int` (1 = internal generator), [6:5] to `word_len`, [7] to `stop2`.
- R4: Mode bit 0 set drives `dtr_n` low and `rx_enable` high; with it clear, `dtr_n` is high, the receiver is disabled and `irq` stays low.
- R5: Mode bits [3:2] give: 00 = `rts_n` high, transmitter off; 01 = `rts_n` low, transmitter on, transmit interrupt on; 10 = `rts_n` low, transmitter on; 11 = `rts_n` low, transmitter on, `tx_break` high.
- R6: With mode bit 0 set and mode bit 1 clear, a high `rx_full` raises `irq` on the next edge; mode bit 1 set masks this source.
- R7: With mode bit 0 set, any level change on `dsr_n` or `dcd_n` raises `irq` once it has passed the synchronizer; status bit 6 shows the synchronized `dsr_n` level and bit 5 the synchronized `dcd_n` level.
- R8: Status bit 7 equals `irq`. A status read clears it unless a source requests an interrupt in the same cycle, and the set wins.
- R9: Status bits 0, 1 and 2 mirror `par_err`, `frm_err` and `ovr_err` and never raise `irq`.
- R10: Status bit 3 mirrors `rx_full` and bit 4 mirrors `tx_empty`.
- R11: After reset both registers read 0, `dtr_n` and `rts_n` are high and `irq` is low.
- R12: Mode bit 4 drives `echo`, bit 5 drives `par_en`, and bits [7:6] drive `par_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| rx_data | input | 8 | Received character from receiver |
| rx_full | input | 1 | Receive register full |
| tx_empty | input | 1 | Transmit register empty |
| par_err | input | 1 | Parity error flag |
| frm_err | input | 1 | Framing error flag |
| ovr_err | input | 1 | Overrun flag |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| tx_load | output | 1 | Pulse: transmit register written |
| rx_read | output | 1 | Pulse: receive register read |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| baud_sel | output | 4 | Rate select code |
| rx_clk_int | output | 1 | Receiver uses internal rate generator |
| word_len | output | 2 | Character length code |
| stop2 | output | 1 | Two stop bits requested |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| tx_break | output | 1 | Send break |
| echo | output | 1 | Echo mode |
| par_en | output | 1 | Parity enabled |
| par_mode | output | 2 | Parity mode |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This confirms that the modem-line interrupt and the live status bits follow the stage count rather than a fixed latency, and that the waits derived from that count stay correct. Everything else uses the defaults. Random mode and line-format bytes, mixed with random receiver and transmitter flags, are compared with an interrupt model computed in the bench. That covers every transmit-control code together with the mask and terminal-ready gates.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        A_DATA  = 2'b00,
        A_STAT  = 2'b01,
        A_MODE  = 2'b10,
        A_LINE  = 2'b11
    } reg_addr_e;

    typedef enum logic [1:0] {
        TXC_OFF   = 2'b00,
        TXC_IRQ   = 2'b01,
        TXC_ON    = 2'b10,
        TXC_BREAK = 2'b11
    } tx_ctl_e;

    typedef struct packed {
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] line;
        logic             pend;
    } regs_t;
endpackage

// File: rtl/uhr_modem_watch.sv
module uhr_modem_watch #(
    parameter int NUM_LINES = 2,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_n,
    output logic [NUM_LINES-1:0] level,
    output logic [NUM_LINES-1:0] changed
);
    localparam int LAST = STAGES - 1;

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two or more stages");
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d,  prev_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], lines_n[g]};
            prev_d  = chain_q[LAST];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign level[g]   = chain_q[LAST];
        assign changed[g] = chain_q[LAST] ^ prev_q;
    end
endmodule

// File: rtl/uhr_cfg_decode.sv
module uhr_cfg_decode
    import uart_host_pkg::*;
(
    input  logic [REG_W-1:0] mode,
    input  logic [REG_W-1:0] line,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             rx_enable,
    output logic             tx_enable,
    output logic             tx_break,
    output logic             echo,
    output logic             par_en,
    output logic [1:0]       par_mode,
    output logic [3:0]       baud_sel,
    output logic             rx_clk_int,
    output logic [1:0]       word_len,
    output logic             stop2
);
    tx_ctl_e txc;

    always_comb begin
        txc        = tx_ctl_e'(mode[3:2]);
        dtr_n      = ~mode[0];
        rx_enable  = mode[0];
        rts_n      = (txc == TXC_OFF);
        tx_enable  = (txc != TXC_OFF);
        tx_break   = (txc == TXC_BREAK);
        echo       = mode[4];
        par_en     = mode[5];
        par_mode   = mode[7:6];
        baud_sel   = line[3:0];
        rx_clk_int = line[4];
        word_len   = line[6:5];
        stop2      = line[7];
    end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [REG_W-1:0] rx_data,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             par_err,
    input  logic             frm_err,
    input  logic             ovr_err,
    input  logic             dsr_n,
    input  logic             dcd_n,
    output logic             tx_load,
    output logic             rx_read,
    output logic             dtr_n,
    output logic             rts_n,
    output logic [3:0]       baud_sel,
    output logic             rx_clk_int,
    output logic [1:0]       word_len,
    output logic             stop2,
    output logic             rx_enable,
    output logic             tx_enable,
    output logic             tx_break,
    output logic             echo,
    output logic             par_en,
    output logic [1:0]       par_mode,
    output logic             irq
);
    localparam int NUM_MODEM = 2;
    localparam int IDX_DCD   = 0;
    localparam int IDX_DSR   = 1;

    regs_t r_d, r_q;

    logic [NUM_MODEM-1:0] m_level, m_changed;
    logic wr_mode, wr_line, wr_preset, stat_rd, set_evt;
    logic [REG_W-1:0] status;

    uhr_modem_watch #(
        .NUM_LINES (NUM_MODEM),
        .STAGES    (SYNC_STAGES)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_n ({dsr_n, dcd_n}),
        .level   (m_level),
        .changed (m_changed)
    );

    always_comb begin
        r_d       = r_q;
        wr_mode   = wr_en && (reg_addr_e'(addr) == A_MODE);
        wr_line   = wr_en && (reg_addr_e'(addr) == A_LINE);
        wr_preset = wr_en && (reg_addr_e'(addr) == A_STAT);
        stat_rd   = rd_en && (reg_addr_e'(addr) == A_STAT);
        if (wr_mode) r_d.mode = wdata;
        if (wr_line) r_d.line = wdata;
        if (wr_preset) begin
            r_d.mode = '0;
            r_d.line = '0;
        end
        set_evt = (rx_full && !r_d.mode[1])
                || ((tx_ctl_e'(r_d.mode[3:2]) == TXC_IRQ) && tx_empty)
                || (|m_changed);
        r_d.pend = r_d.mode[0] && (set_evt || (r_q.pend && !stat_rd && !wr_preset));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    uhr_cfg_decode u_dec (
        .mode       (r_q.mode),
        .line       (r_q.line),
        .dtr_n      (dtr_n),
        .rts_n      (rts_n),
        .rx_enable  (rx_enable),
        .tx_enable  (tx_enable),
        .tx_break   (tx_break),
        .echo       (echo),
        .par_en     (par_en),
        .par_mode   (par_mode),
        .baud_sel   (baud_sel),
        .rx_clk_int (rx_clk_int),
        .word_len   (word_len),
        .stop2      (stop2)
    );

    always_comb begin
        status = {r_q.pend, m_level[IDX_DSR], m_level[IDX_DCD],
                  tx_empty, rx_full, ovr_err, frm_err, par_err};
        unique case (reg_addr_e'(addr))
            A_DATA: rdata = rx_data;
            A_STAT: rdata = status;
            A_MODE: rdata = r_q.mode;
            A_LINE: rdata = r_q.line;
        endcase
        tx_load = wr_en && (reg_addr_e'(addr) == A_DATA);
        rx_read = rd_en && (reg_addr_e'(addr) == A_DATA);
    end

    assign irq = r_q.pend;

    assert_preset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b01) |=> (r_q.mode == '0 && r_q.line == '0 && !irq));
    assert_mode_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b10) |=> (r_q.mode == $past(wdata)));
    assert_irq_needs_dtr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !dtr_n);
    assert_rx_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !r_d.mode[1] && r_d.mode[0]) |=> irq);
    assert_modem_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|m_changed) && r_d.mode[0]) |=> irq);
    assert_status_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_evt) |=> !irq);
endmodule

// File: tb/uart_host_regs_test.sv
module uart_host_regs_test;
    localparam int STG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata, rx_data = '0;
    logic rx_full = 0, tx_empty = 0, par_err = 0, frm_err = 0, ovr_err = 0;
    logic dsr_n = 1, dcd_n = 1;
    logic tx_load, rx_read, dtr_n, rts_n, rx_clk_int, stop2, rx_enable;
    logic tx_enable, tx_break, echo, par_en, irq;
    logic [3:0] baud_sel;
    logic [1:0] word_len, par_mode;

    int n_checks = 0, n_fail = 0;

    always #10 clk = ~clk;

    uart_host_regs #(.SYNC_STAGES(STG)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_full(rx_full),
        .tx_empty(tx_empty), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
        .dsr_n(dsr_n), .dcd_n(dcd_n), .tx_load(tx_load), .rx_read(rx_read),
        .dtr_n(dtr_n), .rts_n(rts_n), .baud_sel(baud_sel), .rx_clk_int(rx_clk_int),
        .word_len(word_len), .stop2(stop2), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .tx_break(tx_break), .echo(echo), .par_en(par_en), .par_mode(par_mode), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic bit exp_irq(input logic [7:0] m, input logic rf, input logic te);
        return m[0] && ((rf && !m[1]) || (m[3:2] == 2'b01 && te));
    endfunction

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1c0ffee));
        ticks(3);
        rst_n = 1'b1;
        ticks(STG + 2);

        // R11 reset state
        check(dtr_n && rts_n && !irq, "R11 outputs", {dtr_n, rts_n, irq}, 3'b110);
        rd(2'b10, v); check(v == 8'h00, "R11 mode", v, 0);
        rd(2'b11, v); check(v == 8'h00, "R11 line", v, 0);

        // R1 address map and strobes
        rx_data = 8'hA5;
        @(negedge clk); addr = 2'b00; rd_en = 1'b1; #1;
        check(rdata == 8'hA5 && rx_read && !tx_load, "R1 data read", rdata, 8'hA5);
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b1; wdata = 8'h3C; #1;
        check(tx_load && !rx_read, "R1 tx_load", tx_load, 1);
        @(negedge clk); wr_en = 1'b0;

        // R3 line-format random
        for (int i = 0; i < 20; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            wr(2'b11, c);
            check({stop2, word_len, rx_clk_int, baud_sel} == c, "R3 fields",
                  {stop2, word_len, rx_clk_int, baud_sel}, c);
            rd(2'b11, v); check(v == c, "R1 line readback", v, c);
        end

        // R4 R5 R6 R12 random modes against interrupt model
        for (int i = 0; i < 40; i++) begin
            logic [7:0] c;
            logic rf, te;
            c = 8'($urandom);
            rf = 1'($urandom); te = 1'($urandom);
            wr(2'b01, 8'($urandom));
            @(negedge clk); rx_full = rf; tx_empty = te;
            wr(2'b10, c);
            check(irq == exp_irq(c, rf, te), "R6 irq model", irq, exp_irq(c, rf, te));
            check(dtr_n == !c[0] && rx_enable == c[0], "R4 dtr", dtr_n, !c[0]);
            check(rts_n == (c[3:2] == 2'b00) && tx_enable == (c[3:2] != 2'b00)
                  && tx_break == (c[3:2] == 2'b11), "R5 tx ctl",
                  {rts_n, tx_enable, tx_break}, c[3:2]);
            check({par_mode, par_en, echo} == c[7:4], "R12 fields",
                  {par_mode, par_en, echo}, c[7:4]);
            rd(2'b10, v); check(v == c, "R1 mode readback", v, c);
        end

        // R2 programmed reset with arbitrary data
        wr(2'b11, 8'hFF); wr(2'b10, 8'h0D);
        wr(2'b01, 8'h5A);
        check(!irq && dtr_n && rts_n && baud_sel == 0, "R2 preset outputs", {irq, dtr_n, rts_n}, 3'b011);
        rd(2'b10, v); check(v == 0, "R2 mode cleared", v, 0);
        rd(2'b11, v); check(v == 0, "R2 line cleared", v, 0);

        // R6 mask and R8 set wins over read
        rx_full = 1'b0; tx_empty = 1'b0;
        wr(2'b10, 8'h03);
        @(negedge clk); rx_full = 1'b1;
        ticks(2); check(!irq, "R6 masked", irq, 0);
        wr(2'b10, 8'h01);
        check(irq, "R6 unmasked", irq, 1);
        rd(2'b01, v); check(v[7] == 1'b1, "R8 bit7", v[7], 1);
        check(irq, "R8 set wins over read", irq, 1);
        @(negedge clk); rx_full = 1'b0;

        // R7 R8 modem change and read clear
        wr(2'b10, 8'h03);
        rd(2'b01, v);
        check(!irq, "R8 cleared", irq, 0);
        @(negedge clk); dsr_n = 1'b0;
        ticks(STG + 2);
        check(irq, "R7 dsr change irq", irq, 1);
        rd(2'b01, v);
        check(v[7] && !v[6] && v[5], "R7 status levels", v[7:5], 3'b101);
        check(!irq, "R8 read clears", irq, 0);
        ticks(3); check(!irq, "R8 stays clear", irq, 0);

        // R4 gating: terminal not ready, change on dcd
        wr(2'b10, 8'h02);
        @(negedge clk); dcd_n = 1'b0;
        ticks(STG + 2);
        check(!irq, "R4 gated", irq, 0);
        rd(2'b01, v); check(v[5] == 1'b0, "R7 dcd level", v[5], 0);

        // R9 R10 error and flag bits
        wr(2'b10, 8'h03);
        @(negedge clk); par_err = 1; frm_err = 1; ovr_err = 1; tx_empty = 1; rx_full = 1;
        ticks(2);
        check(!irq, "R9 errors no irq", irq, 0);
        rd(2'b01, v);
        check(v[2:0] == 3'b111, "R9 error bits", v[2:0], 7);
        check(v[4:3] == 2'b11, "R10 flag bits", v[4:3], 3);
        @(negedge clk); par_err = 0; frm_err = 1; ovr_err = 0; tx_empty = 0; rx_full = 1;
        rd(2'b01, v);
        check(v[4:0] == 5'b01010, "R10 R9 mixed", v[4:0], 5'b01010);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule